// File: doc/BRIEF.md
# Serial Receive Holding Buffer with Per-Entry Status

This block sits between the shift register of a serial receiver and the register interface a processor reads. The shift register hands over each completed character with a one-cycle strobe. The strobe carries up to nine raw data bits, the level sampled for the first stop bit and the received parity bit. The block masks the data to the configured character size and computes a frame-error flag and a parity-error flag. It stores the character in a two-slot first-in first-out queue, and each slot keeps its own data, ninth bit and error flags.

The processor sees the oldest slot through three views: a status view (frame error, overrun, parity error), a ninth-bit view and an eight-bit data view. Software reads the status and the ninth bit first, then pulses the data read, which removes the slot. The block drives a receive-complete flag while any unread slot exists, and an interrupt request gated by two enables. If the queue is full when another character is delivered, that character is lost and an overrun flag is stored with the newest slot. Dropping the receiver enable empties the queue on the next edge.

Top module: `urx_status_buffer`

## Requirements
- R1: After reset the buffer is empty: rx_complete and irq are 0, and view_data, view_bit9 and all three status flags read 0. An empty buffer always shows zeros on every view.
- R2: Characters are stored in arrival order, up to two. The views show the oldest one, and a pulse on rd_data removes it, so the next one becomes visible on the following cycle.
- R3: rx_complete is 1 exactly while at least one unread character is held.
- R4: irq is 1 exactly when rx_complete, rxc_ie and global_ie are all 1.
- R5: A character delivered while two are held and rd_data is low is discarded, and the overrun flag of the newest held character is set. Further characters are dropped the same way until a read frees a slot. The overrun flag shows in the status view once that character becomes the oldest.
- R6: If a character is delivered in the same cycle as rd_data on a full buffer, the read is done first and the new character is stored with its overrun flag 0.
- R7: With parity_check_en = 0 the parity-error flag is stored as 0. With it at 1, the flag is 1 when the received parity bit differs from the expected one. The expected bit is the XOR of the masked data bits for parity_odd = 0, and its inverse for parity_odd = 1.
- R8: The stored frame-error flag is the inverse of frm_stop_bit: 1 when the first stop bit was sampled as 0.
- R9: While rx_enable is 0, every held character is cleared at the next clock edge, rx_complete drops, and delivered characters are ignored.
- R10: char_size codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, code 7 selects 9 bits, and codes 4 to 6 select 8 bits. Bits above the selected size are stored as 0, so view_bit9 is 0 in every mode except code 7.
- R11: A read pulse on an empty buffer has no effect; the next delivered character is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receiver enable; 0 flushes and blocks storage |
| char_size | input | 3 | Character size code |
| parity_check_en | input | 1 | Parity checking on |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| frm_valid | input | 1 | One-cycle strobe: a completed character is delivered |
| frm_data | input | 9 | Raw received data bits, bit 0 first received |
| frm_stop_bit | input | 1 | Level sampled for the first stop bit |
| frm_parity_bit | input | 1 | Received parity bit |
| rd_data | input | 1 | Data view read strobe; removes the oldest character |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| global_ie | input | 1 | Global interrupt enable |
| stat_frame_err | output | 1 | Frame error of the oldest character |
| stat_overrun | output | 1 | Overrun flag of the oldest character |
| stat_parity_err | output | 1 | Parity error of the oldest character |
| view_bit9 | output | 1 | Ninth data bit of the oldest character |
| view_data | output | 8 | Low eight data bits of the oldest character |
| rx_complete | output | 1 | At least one unread character held |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The hardest case to reach is the exact boundary at a full queue. There, a delivered character must either be dropped and mark the newest slot, or be stored because a read lands in the same cycle. The overrun flag is then only visible after one read has moved the marked slot to the head. The stimulus fills both slots and delivers two more characters without reading. It then reads both entries one after the other, expecting overrun only on the second. Separately, it fills the queue again and drives the read and the delivery on the same clock edge.

// File: rtl/urx_pkg.sv
// Shared types and helpers for the serial receive holding buffer.
// Assumes at most nine data bits per character.
package urx_pkg;

    localparam int URX_DATA_W = 9;

    // One held character with its own flags
    typedef struct packed {
        logic [URX_DATA_W-1:0] data;
        logic                  frame_err;
        logic                  parity_err;
        logic                  overrun;
    } urx_entry_t;

    // Number of data bits selected by a size code
    function automatic int urx_bits_for_size(input logic [2:0] code);
        case (code)
            3'd0:    return 5;
            3'd1:    return 6;
            3'd2:    return 7;
            3'd7:    return 9;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/urx_frame_check.sv
// Converts one raw character from the shift register into a stored entry:
// masks the data to the configured size, derives the frame error from the
// first stop bit and the parity error from the masked data.
// Assumes the inputs are stable during the delivery strobe cycle.
module urx_frame_check
    import urx_pkg::*;
(
    input  logic [2:0]            char_size,
    input  logic                  parity_check_en,
    input  logic                  parity_odd,
    input  logic [URX_DATA_W-1:0] raw_data,
    input  logic                  stop_bit,
    input  logic                  parity_bit,
    output urx_entry_t            entry
);

    logic [URX_DATA_W-1:0] size_mask;
    logic [URX_DATA_W-1:0] masked;
    logic                  expect_par;

    // Build the data mask from the size code
    always_comb begin
        for (int i = 0; i < URX_DATA_W; i++) begin
            size_mask[i] = (i < urx_bits_for_size(char_size));
        end
    end

    // Mask data, compute flags
    always_comb begin
        masked           = raw_data & size_mask;
        expect_par       = (^masked) ^ parity_odd;
        entry.data       = masked;
        entry.frame_err  = ~stop_bit;
        entry.parity_err = parity_check_en & (expect_par != parity_bit);
        entry.overrun    = 1'b0;
    end

endmodule

// File: rtl/urx_entry_fifo.sv
// Shift-style queue of DEPTH entries. Slot 0 is always the oldest entry.
// A read is applied before a write in the same cycle. A write to a full
// queue without a read is dropped and marks the newest slot as overrun.
// A low enable empties the queue and zeroes every slot.
// Assumes DEPTH >= 1.
module urx_entry_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             push,
    input  urx_entry_t       push_entry,
    input  logic             pop,
    output urx_entry_t       head,
    output logic [CNT_W-1:0] count
);

    urx_entry_t       slots   [DEPTH];
    urx_entry_t       slots_n [DEPTH];
    logic [CNT_W-1:0] count_n;
    logic             do_pop;
    logic             is_full;
    logic             do_write;
    logic             lost;
    logic [CNT_W-1:0] wr_pos;

    // Decide pop, write and loss for this cycle
    always_comb begin
        is_full  = (count == CNT_W'(DEPTH));
        do_pop   = pop && (count != '0);
        do_write = push && (!is_full || do_pop);
        lost     = push && is_full && !do_pop;
        wr_pos   = do_pop ? count - 1'b1 : count;
    end

    // Compute next slot contents and occupancy
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (do_pop) begin
                slots_n[i] = (i < DEPTH - 1) ? slots[(i + 1) % DEPTH] : '0;
            end else begin
                slots_n[i] = slots[i];
            end
            if (do_write && (CNT_W'(i) == wr_pos)) begin
                slots_n[i] = push_entry;
            end
        end
        if (lost) begin
            slots_n[DEPTH-1].overrun = 1'b1;
        end
        count_n = count;
        if (do_write && !do_pop) begin
            count_n = count + 1'b1;
        end else if (do_pop && !do_write) begin
            count_n = count - 1'b1;
        end
    end

    // Register slots; reset or disable clears everything
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= slots_n[i];
            end
            count <= count_n;
        end
    end

    assign head = slots[0];

endmodule

// File: rtl/urx_flag_gen.sv
// Derives the receive-complete flag from queue occupancy and gates it
// into the interrupt request. Purely combinational.
module urx_flag_gen #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] count,
    input  logic             rxc_ie,
    input  logic             global_ie,
    output logic             rx_complete,
    output logic             irq
);

    // Flag and request
    always_comb begin
        rx_complete = (count != '0);
        irq         = rx_complete && rxc_ie && global_ie;
    end

endmodule

// File: rtl/urx_status_buffer.sv
// Top of the serial receive holding buffer: checks and masks each
// delivered character, queues it with its flags and presents the oldest
// entry through status, ninth-bit and data views.
// Assumes frm_valid is a one-cycle strobe from the receive shift register.
module urx_status_buffer
    import urx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_enable,
    input  logic [2:0]            char_size,
    input  logic                  parity_check_en,
    input  logic                  parity_odd,
    input  logic                  frm_valid,
    input  logic [URX_DATA_W-1:0] frm_data,
    input  logic                  frm_stop_bit,
    input  logic                  frm_parity_bit,
    input  logic                  rd_data,
    input  logic                  rxc_ie,
    input  logic                  global_ie,
    output logic                  stat_frame_err,
    output logic                  stat_overrun,
    output logic                  stat_parity_err,
    output logic                  view_bit9,
    output logic [7:0]            view_data,
    output logic                  rx_complete,
    output logic                  irq
);

    urx_entry_t       new_entry;
    urx_entry_t       head;
    logic [CNT_W-1:0] count;

    urx_frame_check u_check (
        .char_size       (char_size),
        .parity_check_en (parity_check_en),
        .parity_odd      (parity_odd),
        .raw_data        (frm_data),
        .stop_bit        (frm_stop_bit),
        .parity_bit      (frm_parity_bit),
        .entry           (new_entry)
    );

    urx_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_enable),
        .push       (frm_valid),
        .push_entry (new_entry),
        .pop        (rd_data),
        .head       (head),
        .count      (count)
    );

    urx_flag_gen #(.CNT_W(CNT_W)) u_flags (
        .count       (count),
        .rxc_ie      (rxc_ie),
        .global_ie   (global_ie),
        .rx_complete (rx_complete),
        .irq         (irq)
    );

    // Present the oldest entry
    always_comb begin
        view_data       = head.data[7:0];
        view_bit9       = head.data[8];
        stat_frame_err  = head.frame_err;
        stat_parity_err = head.parity_err;
        stat_overrun    = head.overrun;
    end

endmodule

// File: rtl/urx_status_buffer_chk.sv
// Property checker for the serial receive holding buffer, bound to the top.
module urx_status_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic [2:0] char_size,
    input logic       parity_check_en,
    input logic       parity_odd,
    input logic       frm_valid,
    input logic [8:0] frm_data,
    input logic       frm_stop_bit,
    input logic       frm_parity_bit,
    input logic       rd_data,
    input logic       rxc_ie,
    input logic       global_ie,
    input logic       stat_frame_err,
    input logic       stat_overrun,
    input logic       stat_parity_err,
    input logic       view_bit9,
    input logic [7:0] view_data,
    input logic       rx_complete,
    input logic       irq
);

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_complete |-> (view_data == 8'd0 && !view_bit9 && !stat_frame_err
                          && !stat_overrun && !stat_parity_err)); // R1

    AST_PUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frm_valid && !rx_complete) |=> rx_complete); // R3

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_complete && rxc_ie && global_ie)); // R4

    AST_PE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frm_valid && !rx_complete && !parity_check_en)
        |=> !stat_parity_err); // R7

    AST_FE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frm_valid && !rx_complete)
        |=> (stat_frame_err == !$past(frm_stop_bit))); // R8

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !rx_complete); // R9

    AST_NINE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && frm_valid && !rx_complete && char_size != 3'd7)
        |=> !view_bit9); // R10

endmodule

bind urx_status_buffer urx_status_buffer_chk u_chk (.*);

// File: tb/urx_status_buffer_test.sv
// Scoreboard bench: the driver task predicts each stored entry into a
// queue, the monitor task compares the head views against it on each read.
module urx_status_buffer_test;

    typedef struct {
        logic [8:0] data;
        logic       fe;
        logic       pe;
        logic       ovr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic [2:0] char_size = 3'd3;
    logic       parity_check_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       frm_valid = 1'b0;
    logic [8:0] frm_data = '0;
    logic       frm_stop_bit = 1'b1;
    logic       frm_parity_bit = 1'b0;
    logic       rd_data = 1'b0;
    logic       rxc_ie = 1'b0;
    logic       global_ie = 1'b0;
    logic       stat_frame_err, stat_overrun, stat_parity_err, view_bit9;
    logic [7:0] view_data;
    logic       rx_complete, irq;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    urx_status_buffer uut (.*);

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t predict(logic [8:0] d, logic stop, logic pbit);
        exp_t e;
        int   nb;
        case (char_size)
            3'd0: nb = 5;
            3'd1: nb = 6;
            3'd2: nb = 7;
            3'd7: nb = 9;
            default: nb = 8;
        endcase
        e.data = d & 9'((1 << nb) - 1);
        e.fe   = !stop;
        e.pe   = parity_check_en && (pbit != ((^e.data) ^ parity_odd));
        e.ovr  = 1'b0;
        return e;
    endfunction

    // Driver: deliver one character, update the scoreboard
    task automatic send(logic [8:0] d, logic stop, logic pbit, bit with_rd = 0);
        @(negedge clk);
        frm_valid = 1'b1; frm_data = d; frm_stop_bit = stop; frm_parity_bit = pbit;
        rd_data = with_rd;
        if (rx_enable) begin
            if (with_rd && sb.size() > 0) void'(sb.pop_front());
            if (sb.size() < 2) sb.push_back(predict(d, stop, pbit));
            else sb[sb.size()-1].ovr = 1'b1;
        end
        @(negedge clk);
        frm_valid = 1'b0; rd_data = 1'b0;
    endtask

    // Monitor: compare head views with scoreboard front, then pop
    task automatic read_check(string req);
        exp_t e;
        e = sb.pop_front();
        chk(req, "data", int'(view_data), int'(e.data[7:0]));
        chk(req, "bit9", int'(view_bit9), int'(e.data[8]));
        chk(req, "fe", int'(stat_frame_err), int'(e.fe));
        chk(req, "pe", int'(stat_parity_err), int'(e.pe));
        chk(req, "ovr", int'(stat_overrun), int'(e.ovr));
        @(negedge clk) rd_data = 1'b1;
        @(negedge clk) rd_data = 1'b0;
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rxc", int'(rx_complete), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "views", int'({view_bit9, view_data, stat_frame_err,
                                 stat_overrun, stat_parity_err}), 0);
        rst_n = 1'b1; rx_enable = 1'b1;

        // R2 R3: single 8-bit character
        send(9'h0A5, 1, 0);
        chk("R3", "rxc one", int'(rx_complete), 1);
        read_check("R2");
        chk("R3", "rxc empty", int'(rx_complete), 0);

        // R2 R10: 9-bit order
        char_size = 3'd7;
        send(9'h1C3, 1, 0);
        send(9'h03C, 1, 0);
        read_check("R2");
        read_check("R10");

        // R4: interrupt gating
        send(9'h011, 1, 0);
        chk("R4", "irq no ie", int'(irq), 0);
        rxc_ie = 1; #1 chk("R4", "irq only rxcie", int'(irq), 0);
        global_ie = 1; #1 chk("R4", "irq both", int'(irq), 1);
        rxc_ie = 0; #1 chk("R4", "irq gie only", int'(irq), 0);
        rxc_ie = 1;
        read_check("R2");
        chk("R4", "irq empty", int'(irq), 0);

        // R5: overrun after two held
        char_size = 3'd3;
        send(9'h001, 1, 0);
        send(9'h002, 1, 0);
        send(9'h003, 1, 0);
        send(9'h004, 1, 0);
        read_check("R5");
        read_check("R5");
        chk("R5", "rxc after drain", int'(rx_complete), 0);

        // R6: same-cycle read and delivery on full
        send(9'h021, 1, 0);
        send(9'h022, 1, 0);
        send(9'h023, 1, 0, 1);
        read_check("R6");
        read_check("R6");

        // R7: parity disabled, even, odd
        send(9'h007, 1, 0);
        read_check("R7");
        parity_check_en = 1;
        send(9'h007, 1, 1);
        send(9'h007, 1, 0);
        read_check("R7");
        read_check("R7");
        parity_odd = 1;
        send(9'h006, 1, 0);
        send(9'h006, 1, 1);
        read_check("R7");
        read_check("R7");
        parity_check_en = 0; parity_odd = 0;

        // R8: frame error from stop bit
        send(9'h055, 0, 0);
        send(9'h056, 1, 0);
        read_check("R8");
        read_check("R8");

        // R9: flush and ignore while disabled
        send(9'h031, 1, 0);
        send(9'h032, 1, 0);
        @(negedge clk) rx_enable = 0;
        @(negedge clk);
        sb.delete();
        chk("R9", "rxc flushed", int'(rx_complete), 0);
        chk("R9", "view flushed", int'(view_data), 0);
        send(9'h033, 1, 0);
        chk("R9", "ignored", int'(rx_complete), 0);
        rx_enable = 1;

        // R10: 5-bit masking
        char_size = 3'd0;
        send(9'h1FF, 1, 0);
        read_check("R10");
        char_size = 3'd5;
        send(9'h1FF, 1, 0);
        read_check("R10");

        // R11: read on empty
        @(negedge clk) rd_data = 1;
        @(negedge clk) rd_data = 0;
        chk("R11", "rxc", int'(rx_complete), 0);
        char_size = 3'd3;
        send(9'h0E7, 1, 0);
        read_check("R11");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule